// File: doc/BRIEF.md
# GPIO Port with Peripheral Function Multiplexer

This block is a 16-pin general-purpose I/O port behind a simple register bus. Each pin belongs either to the GPIO logic or to one of four peripheral lanes. A per-pin function-enable bit makes that choice. A 2-bit code per pin picks the lane. Output data and direction each have atomic set and clear aliases, so software can change single pins without a read-modify-write. An input-enable mask is kept apart from direction and decides whether a sampled pad value is visible.

Pad inputs pass through a two-stage synchroniser. The synchronised values go, ungated, to the peripherals as per-pin samples. The synchronised values, masked by input-enable, go to a downstream pin-interrupt block. Reads are combinational on the registered state: the read data reflects every write that was clocked in before the read.

Top module: `gpm_port`

Address codes (bus_addr): 0 = data (read returns pin state, write loads the output data register), 1 = data-set, 2 = data-clear, 3 = direction-set, 4 = direction-clear, 5 = input-enable, 6 = function-enable, 7 = function-select (whole 32 bits), 8 = function-select single field (wdata[19:16] = pin, wdata[1:0] = code). Any other code reads as 0.

## Requirements
- R1: After reset, every register is 0, every pad_oe bit is 0, every address reads 0, and irq_vec is 0.
- R2: A write to address 1 sets exactly the data bits written as 1. A write to address 2 clears exactly the data bits written as 1. Every other data bit keeps its value.
- R3: A write to address 3 sets direction bits written as 1, which makes those pins outputs. A write to address 4 clears direction bits written as 1, which makes those pins inputs. No other direction bit changes.
- R4: A write to address 0 loads all 16 bits of the output data register. A write to address 5 loads the whole input-enable mask. A write to address 6 loads the whole function-enable mask. A write to address 7 loads all 32 bits of function-select.
- R5: Reading address 0 returns 0 for a pin that is an input (direction 0) and has input-enable 0, whatever its pad level.
- R6: For an input pin with input-enable 1, a pad level applied before a clock edge appears in the address-0 readback and in irq_vec after the second clock edge, and not after the first. irq_vec is the synchronised pad level ANDed with input-enable, and pin_sample is the synchronised pad level.
- R7: For an output pin (direction 1), the address-0 readback bit equals its output data bit.
- R8: A pin with function-enable 0 drives pad_out from its data bit and pad_oe from its direction bit.
- R9: A pin with function-enable 1 drives pad_out and pad_oe from lane_out and lane_oe bit [k*16 + pin]. Here k is the pin's function-select field, held at bits [2*pin+1 : 2*pin].
- R10: A write to address 8 changes only the function-select field of the pin named in wdata[19:16], setting it to wdata[1:0]. All other fields keep their value.
- R11: Reading address 1 or 2 returns the data register. Reading 3 or 4 returns direction. Reading 5, 6, 7 or 8 returns input-enable, function-enable, function-select and function-select respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 4 | Register address code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| pin_sample | output | 16 | Synchronised pad levels for peripherals |
| irq_vec | output | 16 | Synchronised, input-enable-gated levels for the interrupt block |
| lane_out | input | 64 | Peripheral output levels, lane k at bits [16k+15:16k] |
| lane_oe | input | 64 | Peripheral output enables, same packing as lane_out |

## Verification
Two functions can meet in one cycle: a direction-clear write hands a pin back to the input path while a new pad level is still inside the synchroniser. The bench drives both in the same cycle. It then expects the readback to show the stale synchronised level after one edge and the new level after the second edge, never the old driven data. The same path is also crossed by random mixes of register writes and pad changes, which are judged against a bench model of the register semantics.

// File: rtl/gpm_pkg.sv
// Package: address codes and shared sizes for the GPIO multiplexed port.
// Assumes a 4-bit address and a 32-bit data bus.
package gpm_pkg;
    localparam int BUS_W = 32;
    localparam int ADDR_W = 4;
    localparam int LANES = 4;

    localparam logic [ADDR_W-1:0] A_DATA     = 4'd0;
    localparam logic [ADDR_W-1:0] A_DATA_SET = 4'd1;
    localparam logic [ADDR_W-1:0] A_DATA_CLR = 4'd2;
    localparam logic [ADDR_W-1:0] A_DIR_SET  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DIR_CLR  = 4'd4;
    localparam logic [ADDR_W-1:0] A_INEN     = 4'd5;
    localparam logic [ADDR_W-1:0] A_FEN      = 4'd6;
    localparam logic [ADDR_W-1:0] A_FSEL     = 4'd7;
    localparam logic [ADDR_W-1:0] A_FSEL_ONE = 4'd8;
endpackage

// File: rtl/gpm_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherence is provided.
module gpm_sync #(
    parameter int W = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift each stage forward by one clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpm_regs.sv
// Module: register file for the port. It holds data, direction, input-enable,
// function-enable and function-select, with atomic set/clear aliases and a
// single-field select write. Assumes W <= 16 so that the selector fits the bus.
module gpm_regs
    import gpm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      inen_q,
    output logic [W-1:0]      fen_q,
    output logic [2*W-1:0]    fsel_q
);
    localparam int SEL_W = 2 * W;

    logic [W-1:0]     wbits;
    logic [3:0]       fidx;
    logic [SEL_W-1:0] fmask;
    logic [SEL_W-1:0] fval;

    // Decode the single-field select write into a mask and a replicated value.
    always_comb begin
        wbits = wdata[W-1:0];
        fidx  = wdata[19:16];
        fmask = '0;
        if (int'(fidx) < W) fmask = {{(SEL_W-2){1'b0}}, 2'b11} << (2 * fidx);
        fval  = {W{wdata[1:0]}};
    end

    // Register updates; one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            inen_q <= '0;
            fen_q  <= '0;
            fsel_q <= '0;
        end else if (we) begin
            case (addr)
                A_DATA:     data_q <= wbits;
                A_DATA_SET: data_q <= data_q | wbits;
                A_DATA_CLR: data_q <= data_q & ~wbits;
                A_DIR_SET:  dir_q  <= dir_q | wbits;
                A_DIR_CLR:  dir_q  <= dir_q & ~wbits;
                A_INEN:     inen_q <= wbits;
                A_FEN:      fen_q  <= wbits;
                A_FSEL:     fsel_q <= wdata[SEL_W-1:0];
                A_FSEL_ONE: fsel_q <= (fsel_q & ~fmask) | (fval & fmask);
                default: ;
            endcase
        end
    end

    AST_DSET_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_DATA_SET) |=>
        ((data_q & $past(wbits)) == $past(wbits)) &&
        ((data_q & ~$past(wbits)) == ($past(data_q) & ~$past(wbits)))); // R2
    AST_DCLR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_DATA_CLR) |=>
        ((data_q & $past(wbits)) == '0) &&
        ((data_q & ~$past(wbits)) == ($past(data_q) & ~$past(wbits)))); // R2
    AST_DIR_SET_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == A_DIR_SET || addr == A_DIR_CLR)) |=>
        ((dir_q & ~$past(wbits)) == ($past(dir_q) & ~$past(wbits)))); // R3
    AST_FSEL_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_FSEL_ONE) |=>
        ((fsel_q & ~$past(fmask)) == ($past(fsel_q) & ~$past(fmask)))); // R10
    AST_FSEL_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_FSEL_ONE) |=> ($countones($past(fmask)) <= 2)); // R10
endmodule

// File: rtl/gpm_padmux.sv
// Module: per-pin pad multiplexer. It chooses between GPIO data/direction and
// one of LANES peripheral lanes, indexed by the pin's 2-bit select field.
// Assumes lane buses pack lane k at bits [k*W +: W].
module gpm_padmux
    import gpm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]       data_q,
    input  logic [W-1:0]       dir_q,
    input  logic [W-1:0]       fen_q,
    input  logic [2*W-1:0]     fsel_q,
    input  logic [LANES*W-1:0] lane_out,
    input  logic [LANES*W-1:0] lane_oe,
    output logic [W-1:0]       pad_out,
    output logic [W-1:0]       pad_oe
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            logic [1:0] sel;
            // Select the pad source for pin i.
            always_comb begin
                sel = fsel_q[2*i +: 2];
                if (fen_q[i]) begin
                    pad_out[i] = lane_out[int'(sel) * W + i];
                    pad_oe[i]  = lane_oe[int'(sel) * W + i];
                end else begin
                    pad_out[i] = data_q[i];
                    pad_oe[i]  = dir_q[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpm_port.sv
// Module: top of the GPIO port. It ties together the register file, the pad
// multiplexer and the input synchroniser, and decodes the combinational
// readback. Assumes W <= 16.
module gpm_port
    import gpm_pkg::*;
#(
    parameter int W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pin_sample,
    output logic [W-1:0]      irq_vec,
    input  logic [LANES*W-1:0] lane_out,
    input  logic [LANES*W-1:0] lane_oe
);
    logic [W-1:0]   data_q, dir_q, inen_q, fen_q, sync_q, pin_state;
    logic [2*W-1:0] fsel_q;

    gpm_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .data_q(data_q), .dir_q(dir_q), .inen_q(inen_q), .fen_q(fen_q), .fsel_q(fsel_q)
    );

    gpm_padmux #(.W(W)) u_padmux (
        .data_q(data_q), .dir_q(dir_q), .fen_q(fen_q), .fsel_q(fsel_q),
        .lane_out(lane_out), .lane_oe(lane_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    gpm_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
    );

    // Pin state: outputs show driven data, inputs show gated samples.
    always_comb begin
        pin_state  = (dir_q & data_q) | (~dir_q & inen_q & sync_q);
        pin_sample = sync_q;
        irq_vec    = sync_q & inen_q;
    end

    // Combinational readback multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA:                 bus_rdata[W-1:0]   = pin_state;
            A_DATA_SET, A_DATA_CLR: bus_rdata[W-1:0]   = data_q;
            A_DIR_SET, A_DIR_CLR:   bus_rdata[W-1:0]   = dir_q;
            A_INEN:                 bus_rdata[W-1:0]   = inen_q;
            A_FEN:                  bus_rdata[W-1:0]   = fen_q;
            A_FSEL, A_FSEL_ONE:     bus_rdata[2*W-1:0] = fsel_q;
            default: ;
        endcase
    end

    AST_GPIO_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~fen_q & ~dir_q) == '0); // R8
    AST_DISABLED_INPUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DATA) |-> ((bus_rdata[W-1:0] & ~dir_q & ~inen_q) == '0)); // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec & ~inen_q) == '0); // R6
    AST_OUTPUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DATA) |-> ((bus_rdata[W-1:0] & dir_q) == (data_q & dir_q))); // R7
endmodule

// File: tb/gpm_port_tb.sv
module gpm_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out, pad_oe, pin_sample, irq_vec;
    logic [4*W-1:0] lane_out = '0;
    logic [4*W-1:0] lane_oe = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [W-1:0]   m_data = '0, m_dir = '0, m_inen = '0, m_fen = '0;
    logic [2*W-1:0] m_fsel = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpm_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin_sample(pin_sample),
        .irq_vec(irq_vec), .lane_out(lane_out), .lane_oe(lane_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply a write to the bench model by the register semantics.
    task automatic model_wr(input logic [3:0] a, input logic [31:0] d);
        case (a)
            4'd0: m_data = d[W-1:0];
            4'd1: m_data = m_data | d[W-1:0];
            4'd2: m_data = m_data & ~d[W-1:0];
            4'd3: m_dir  = m_dir | d[W-1:0];
            4'd4: m_dir  = m_dir & ~d[W-1:0];
            4'd5: m_inen = d[W-1:0];
            4'd6: m_fen  = d[W-1:0];
            4'd7: m_fsel = d;
            4'd8: if (int'(d[19:16]) < W) m_fsel[2*d[19:16] +: 2] = d[1:0];
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_rd(input logic [3:0] a, input logic [W-1:0] pins);
        case (a)
            4'd0: return {16'h0, (m_dir & m_data) | (~m_dir & m_inen & pins)};
            4'd1, 4'd2: return {16'h0, m_data};
            4'd3, 4'd4: return {16'h0, m_dir};
            4'd5: return {16'h0, m_inen};
            4'd6: return {16'h0, m_fen};
            4'd7, 4'd8: return m_fsel;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_pad(input bit oe);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int k = int'(m_fsel[2*i +: 2]);
            if (m_fen[i]) r[i] = oe ? lane_oe[k*W+i] : lane_out[k*W+i];
            else r[i] = oe ? m_dir[i] : m_data[i];
        end
        return r;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        model_wr(a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [W-1:0] pins);
        bus_addr = a;
        #1;
        chk(req, $sformatf("read addr %0d", a), bus_rdata, exp_rd(a, pins));
    endtask

    task automatic pads_chk(input string req);
        chk(req, "pad_out", {16'h0, pad_out}, {16'h0, exp_pad(1'b0)});
        chk(req, "pad_oe", {16'h0, pad_oe}, {16'h0, exp_pad(1'b1)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pad_in = 16'hFFFF;
        // R1: reset state
        for (int a = 0; a < 10; a++) rd_chk("R1", 4'(a), 16'h0);
        chk("R1", "pad_oe after reset", {16'h0, pad_oe}, 32'h0);
        repeat (2) @(negedge clk);
        chk("R1", "irq_vec with inputs disabled", {16'h0, irq_vec}, 32'h0);
        // R5: input disabled reads 0 despite high pads
        rd_chk("R5", 4'd0, pad_in);
        // R4 and R2
        wr(4'd0, 32'h0000_A5A5); rd_chk("R4", 4'd1, pad_in);
        wr(4'd1, 32'h0000_0F0F); rd_chk("R2", 4'd1, pad_in);
        wr(4'd2, 32'h0000_8001); rd_chk("R2", 4'd2, pad_in);
        // R3
        wr(4'd3, 32'h0000_00FF); rd_chk("R3", 4'd3, pad_in);
        wr(4'd4, 32'h0000_0011); rd_chk("R3", 4'd4, pad_in);
        // R7 and R8: outputs read back data, pads follow GPIO
        rd_chk("R7", 4'd0, pad_in);
        pads_chk("R8");
        // R6: latency of the input path
        wr(4'd5, 32'h0000_FFFF);
        @(negedge clk); pad_in = 16'h1234;
        @(negedge clk); bus_addr = 4'd0; #1;
        chk("R6", "readback after one edge", bus_rdata, exp_rd(4'd0, 16'hFFFF));
        @(negedge clk); rd_chk("R6", 4'd0, 16'h1234);
        chk("R6", "irq_vec", {16'h0, irq_vec}, {16'h0, 16'h1234 & m_inen});
        chk("R6", "pin_sample", {16'h0, pin_sample}, {16'h0, 16'h1234});
        // R4, R10, R11: function select writes and aliases
        wr(4'd7, 32'hE4E4_1B1B); rd_chk("R4", 4'd7, pad_in);
        wr(4'd8, 32'h0005_0002); rd_chk("R10", 4'd7, pad_in);
        wr(4'd8, 32'h000F_0003); rd_chk("R10", 4'd8, pad_in);
        rd_chk("R11", 4'd2, pad_in); rd_chk("R11", 4'd5, pad_in);
        // R9: peripheral lanes
        lane_out = {16'hFFFF, 16'h00FF, 16'h0F0F, 16'h3333};
        lane_oe  = {16'hAAAA, 16'h5555, 16'hF00F, 16'h0FF0};
        wr(4'd6, 32'h0000_C3A5); pads_chk("R9");
        // Same-cycle corner: direction-clear write while a new level is in flight
        wr(4'd6, 32'h0); wr(4'd0, 32'h0000_0001); wr(4'd3, 32'h0000_0001);
        pad_in = 16'h0000; repeat (3) @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h1; pad_in = 16'h0001;
        model_wr(4'd4, 32'h1);
        @(negedge clk); bus_we = 1'b0; bus_addr = 4'd0; #1;
        chk("R6", "dir cleared, stale sample", bus_rdata, exp_rd(4'd0, 16'h0000));
        @(negedge clk); rd_chk("R6", 4'd0, 16'h0001);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [3:0] a = 4'($urandom_range(0, 8));
            logic [31:0] d = $urandom;
            lane_out = {$urandom, $urandom};
            lane_oe  = {$urandom, $urandom};
            pad_in = 16'($urandom);
            wr(a, d);
            @(negedge clk);
            rd_chk("R7", 4'd0, pad_in);
            rd_chk("R11", 4'($urandom_range(1, 8)), pad_in);
            pads_chk("R9");
            chk("R6", "irq_vec random", {16'h0, irq_vec}, {16'h0, pad_in & m_inen});
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule